// File: doc/BRIEF.md
# OTP Fuse Word Read Controller

This block lets software fetch 32-bit words from a one-time-programmable fuse array over a simple register bus with separate read and write strobes. Software first loads a timing register that holds cycle counts for the relax and read-strobe phases. It then writes the wanted fuse word index into the control register and fires the read-trigger register. A small sequencer steps through the phases PH_IDLE, PH_SETUP, PH_STROBE and PH_HOLD. During the read a busy flag is visible in the control register. When the read ends, the fuse word appears in a read-only data register.

The transitions are as follows. PH_IDLE goes to PH_SETUP on an accepted trigger. PH_SETUP goes to PH_STROBE after relax+1 cycles. PH_STROBE goes to PH_HOLD after strobe+1 cycles. PH_HOLD goes back to PH_IDLE after relax+1 cycles, and the data register is loaded on that last edge. Control bits can be set or cleared through two alias addresses without a read-modify-write. A read started while the error flag is set does not stop early. It runs its full timing and then delivers a fixed poison word. The fuse contents come from a parameter, and the bus cannot change them.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, control (0x00) and timing (0x10) read 0, the busy bit (control bit 8) is 0, and the data register (0x40) reads 0.
- R2: A write to control at 0x00 stores only the word index [6:0], the error bit [9], the reload bit [10] and the key field [31:16]. Bits 7, 8 and [15:11] always read 0, and busy (bit 8) cannot be written.
- R3: A write to 0x04 ORs the writable bits of the value into control. A write to 0x08 clears every control bit that is 1 in the value. Control also reads back at 0x04 and 0x08.
- R4: The timing register at 0x10 holds bits [21:0]: read-strobe count in [21:16], relax count in [15:12], program-strobe count in [11:0]. Bits [31:22] read 0.
- R5: Writing a value with bit 0 set to 0x30, while not busy, starts a read of the word indexed by control[6:0]. Busy reads 1 for exactly 2*(relax+1)+(strobe+1) cycles, counted from the write edge. The counts and the index are captured at the start of the read.
- R6: A read that starts with the error bit clear loads data (0x40) with word(i) = FUSE_SEED XOR (i * 32'h9E3779B1), truncated to 32 bits. Data changes at no other time.
- R7: A trigger while busy does not start a new read and sets the error bit. The running read finishes with its own timing and result.
- R8: A trigger while idle with the error bit set runs the full timed read, loads data with 32'hBADABADA, and leaves the error bit set. Writing bit 9 to 0x08 clears the error bit.
- R9: Writes to 0x40 have no effect. A write to 0x30 with bit 0 clear starts nothing. 0x30 reads 0.
- R10: Writes to unmapped offsets change no register, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when bus_rd is low |

## Verification
The bench builds the block with its default field widths (4-bit relax, 6-bit read strobe) and a fixed FUSE_SEED, so it can compute every fuse word itself from the formula in R6. With these widths the longest read lasts 96 cycles. This allows many random reads of random words with random counts, plus a directed read at the maximum counts and a directed read at the minimum counts. The random reads measure the busy window cycle by cycle. The directed cases cover a trigger during a running read, a read started with the error bit set, the set and clear aliases, and writes to read-only and unmapped offsets.

// File: rtl/otp_pkg.sv
package otp_pkg;
    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_t;

    localparam logic [7:0] OFS_CTRL     = 8'h00;
    localparam logic [7:0] OFS_CTRL_SET = 8'h04;
    localparam logic [7:0] OFS_CTRL_CLR = 8'h08;
    localparam logic [7:0] OFS_TIMING   = 8'h10;
    localparam logic [7:0] OFS_TRIG     = 8'h30;
    localparam logic [7:0] OFS_DATA     = 8'h40;

    localparam int BIT_BUSY = 8;
    localparam int BIT_ERR  = 9;

    localparam int IDX_W     = 7;
    localparam int RELAX_LSB = 12;
    localparam int RELAX_W   = 4;
    localparam int STRB_LSB  = 16;
    localparam int STRB_W    = 6;

    localparam logic [31:0] CTRL_WMASK   = 32'hFFFF_067F;
    localparam logic [31:0] TIMING_WMASK = 32'h003F_FFFF;
    localparam logic [31:0] POISON_WORD  = 32'hBADA_BADA;

    function automatic logic [31:0] fuse_word(input logic [31:0] seed,
                                              input logic [IDX_W-1:0] idx);
        logic [31:0] prod;
        prod = 32'(idx) * 32'h9E37_79B1;
        return seed ^ prod;
    endfunction
endpackage

// File: rtl/otp_fuse_rom.sv
module otp_fuse_rom
    import otp_pkg::*;
#(
    parameter logic [31:0] SEED = 32'h0,
    parameter int          IDXW = 7
) (
    input  logic [IDXW-1:0] idx,
    output logic [31:0]     word
);
    localparam int WORDS = 1 << IDXW;

    logic [31:0] cells [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_cell
        assign cells[g] = fuse_word(SEED, IDX_W'(g));
    end

    assign word = cells[idx];
endmodule

// File: rtl/otp_read_seq.sv
module otp_read_seq
    import otp_pkg::*;
#(
    parameter int RLX_W = 4,
    parameter int STB_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [RLX_W-1:0] relax_i,
    input  logic [STB_W-1:0] strobe_i,
    output logic             busy_o,
    output logic             done_o
);
    localparam int CNT_W = (RLX_W > STB_W) ? RLX_W : STB_W;

    phase_t           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [RLX_W-1:0] relax_q, relax_d;
    logic [STB_W-1:0] strobe_q, strobe_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PH_IDLE;
            cnt_q    <= '0;
            relax_q  <= '0;
            strobe_q <= '0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            relax_q  <= relax_d;
            strobe_q <= strobe_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        relax_d  = relax_q;
        strobe_d = strobe_q;
        unique case (state_q)
            PH_IDLE: begin
                if (start) begin
                    state_d  = PH_SETUP;
                    cnt_d    = CNT_W'(relax_i);
                    relax_d  = relax_i;
                    strobe_d = strobe_i;
                end
            end
            PH_SETUP: begin
                if (cnt_q == '0) begin
                    state_d = PH_STROBE;
                    cnt_d   = CNT_W'(strobe_q);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_STROBE: begin
                if (cnt_q == '0) begin
                    state_d = PH_HOLD;
                    cnt_d   = CNT_W'(relax_q);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_HOLD: begin
                if (cnt_q == '0) begin
                    state_d = PH_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        busy_o = (state_q != PH_IDLE);
        done_o = (state_q == PH_HOLD) && (cnt_q == '0);
    end

    // R5: phases only advance in the fixed order
    a_r5_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_IDLE) |=> (state_q inside {PH_IDLE, PH_SETUP}));
    a_r5_setup_next: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_SETUP) |=> (state_q inside {PH_SETUP, PH_STROBE}));
    a_r5_strobe_next: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_STROBE) |=> (state_q inside {PH_STROBE, PH_HOLD}));
    a_r5_hold_next: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_HOLD) |=> (state_q inside {PH_HOLD, PH_IDLE}));
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_pkg::*;
#(
    parameter logic [31:0] FUSE_SEED = 32'h5A5A_1234
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    logic [31:0]      ctrl_q, timing_q, data_q;
    logic [IDX_W-1:0] idx_q;
    logic             fail_q;
    logic             seq_busy, seq_done, trig, start;
    logic [31:0]      rom_word, ctrl_view;

    assign trig  = bus_wr && (bus_addr == OFS_TRIG) && bus_wdata[0];
    assign start = trig && !seq_busy;

    otp_read_seq #(.RLX_W(RELAX_W), .STB_W(STRB_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .relax_i  (timing_q[RELAX_LSB +: RELAX_W]),
        .strobe_i (timing_q[STRB_LSB +: STRB_W]),
        .busy_o   (seq_busy),
        .done_o   (seq_done)
    );

    otp_fuse_rom #(.SEED(FUSE_SEED), .IDXW(IDX_W)) u_rom (
        .idx  (idx_q),
        .word (rom_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            timing_q <= '0;
            data_q   <= '0;
            idx_q    <= '0;
            fail_q   <= 1'b0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    OFS_CTRL:     ctrl_q   <= bus_wdata & CTRL_WMASK;
                    OFS_CTRL_SET: ctrl_q   <= ctrl_q | (bus_wdata & CTRL_WMASK);
                    OFS_CTRL_CLR: ctrl_q   <= ctrl_q & ~bus_wdata;
                    OFS_TIMING:   timing_q <= bus_wdata & TIMING_WMASK;
                    default: ;
                endcase
            end
            if (trig && seq_busy) begin
                ctrl_q[BIT_ERR] <= 1'b1;
            end
            if (start) begin
                idx_q  <= ctrl_q[IDX_W-1:0];
                fail_q <= ctrl_q[BIT_ERR];
            end
            if (seq_done) begin
                data_q <= fail_q ? POISON_WORD : rom_word;
            end
        end
    end

    always_comb begin
        ctrl_view           = ctrl_q;
        ctrl_view[BIT_BUSY] = seq_busy;
        bus_rdata           = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_CTRL, OFS_CTRL_SET, OFS_CTRL_CLR: bus_rdata = ctrl_view;
                OFS_TIMING: bus_rdata = timing_q;
                OFS_DATA:   bus_rdata = data_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    a_r5_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> seq_busy);
    a_r7_busy_trig_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && seq_busy) |=> ctrl_q[BIT_ERR]);
    a_r6_data_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_done |=> $stable(data_q));
    a_r8_poison_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && fail_q) |=> (data_q == POISON_WORD));
endmodule

// File: tb/tb_otp_fuse_ctrl.sv
`timescale 1ns/1ps
module tb_otp_fuse_ctrl;
    localparam logic [31:0] SEED   = 32'h5A5A_1234;
    localparam logic [31:0] POISON = 32'hBADA_BADA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_run = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    otp_fuse_ctrl #(.FUSE_SEED(SEED)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] exp_word(input logic [6:0] i);
        logic [31:0] p;
        p = 32'(i) * 32'h9E37_79B1;
        return SEED ^ p;
    endfunction

    function automatic int exp_len(input int rlx, input int stb);
        return 2 * (rlx + 1) + stb + 1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic busy_len(output int n);
        logic [31:0] v;
        n = 0;
        rd(8'h00, v);
        while (v[8] && n < 1000) begin
            n++;
            rd(8'h00, v);
        end
    endtask

    task automatic do_read(input int rlx, input int stb, input logic [6:0] idx,
                           input logic [15:0] key, input string req);
        logic [31:0] v;
        int n;
        wr(8'h10, {10'h0, 6'(stb), 4'(rlx), 12'hABC});
        wr(8'h00, {key, 9'h0, idx});
        wr(8'h30, 32'h1);
        busy_len(n);
        chk({req, " busy length"}, 32'(n), 32'(exp_len(rlx, stb)));
        rd(8'h40, v);
        chk({req, " data"}, v, exp_word(idx));
    endtask

    initial begin
        #(4 * 150000);
        if (!done_flag) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, w;
        int n;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk("R1 control", v, 32'h0);
        rd(8'h10, v); chk("R1 timing", v, 32'h0);
        rd(8'h40, v); chk("R1 data", v, 32'h0);

        // R2 direct control write, busy bit read-only
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R2 writable mask", v, 32'hFFFF_067F);
        wr(8'h00, 32'h3E77_0155);
        rd(8'h00, v); chk("R2 key and index", v, 32'h3E77_0055);

        // R3 set and clear aliases
        wr(8'h04, 32'h0000_0500);
        rd(8'h00, v); chk("R3 set alias", v, 32'h3E77_0455);
        wr(8'h08, 32'h3000_0015);
        rd(8'h08, v); chk("R3 clear alias", v, 32'h0E77_0440);
        rd(8'h04, v); chk("R3 set alias readback", v, 32'h0E77_0440);
        wr(8'h08, 32'hFFFF_FFFF);

        // R4 timing register
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R4 timing mask", v, 32'h003F_FFFF);

        // R10 unmapped offsets
        wr(8'h20, 32'h1234_5678);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h20, v); chk("R10 unmapped read", v, 32'h0);
        rd(8'h00, v); chk("R10 control untouched", v, 32'h0);
        rd(8'h10, v); chk("R10 timing untouched", v, 32'h003F_FFFF);

        // R5 R6 directed extremes
        do_read(0, 0, 7'd0, 16'h0, "R5 R6 min counts");
        do_read(15, 63, 7'd127, 16'h3E77, "R5 R6 max counts");

        // R9 read-only data, trigger bit 0 clear
        wr(8'h40, 32'h1234_5678);
        rd(8'h40, v); chk("R9 data write ignored", v, exp_word(7'd127));
        wr(8'h30, 32'hFFFF_FFFE);
        rd(8'h00, v); chk("R9 no start without bit0", {31'h0, v[8]}, 32'h0);
        rd(8'h30, v); chk("R9 trigger reads zero", v, 32'h0);

        // R5 counts captured at start
        wr(8'h10, {10'h0, 6'd10, 4'd2, 12'h0});
        wr(8'h00, 32'd33);
        wr(8'h30, 32'h1);
        wr(8'h10, 32'h0);
        wr(8'h00, 32'd5);
        busy_len(n);
        chk("R5 latched length", 32'(n + 2), 32'(exp_len(2, 10)));
        rd(8'h40, v); chk("R5 latched index", v, exp_word(7'd33));

        // R7 trigger during a read
        wr(8'h10, {10'h0, 6'd20, 4'd3, 12'h0});
        wr(8'h00, 32'd77);
        wr(8'h30, 32'h1);
        wr(8'h30, 32'h1);
        busy_len(n);
        chk("R7 running read length", 32'(n + 1), 32'(exp_len(3, 20)));
        rd(8'h00, v); chk("R7 error set", {31'h0, v[9]}, 32'h1);
        rd(8'h40, v); chk("R7 running read data", v, exp_word(7'd77));

        // R8 trigger with error set
        wr(8'h00, 32'h0000_0200 | 32'd9);
        wr(8'h30, 32'h1);
        busy_len(n);
        chk("R8 full length", 32'(n), 32'(exp_len(3, 20)));
        rd(8'h40, v); chk("R8 poison", v, POISON);
        rd(8'h00, v); chk("R8 error kept", {31'h0, v[9]}, 32'h1);
        wr(8'h08, 32'h0000_0200);
        rd(8'h00, v); chk("R8 error cleared", {31'h0, v[9]}, 32'h0);

        // R5 R6 random reads
        for (int k = 0; k < 40; k++) begin
            int rr, ss;
            logic [6:0] ii;
            rr = int'($urandom % 16);
            ss = int'($urandom % 64);
            ii = 7'($urandom);
            w  = $urandom;
            do_read(rr, ss, ii, w[15:0], "R5 R6 random");
        end

        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule